// File: doc/BRIEF.md
# Power-On Fail-Safe Sequencer

This block makes the power-up decision for a fan controller. It starts in a waiting state after reset. If the processor supply is reported good, it runs a timeout measured in clock cycles. If no valid bus transaction addressed to the device arrives before the timeout ends, the block commands the fans to full speed. It holds that command until a transaction finally arrives. That transaction switches the fans off, loads the default settings and starts normal operation. A transaction that arrives before the timeout, or while the supply is still low, goes straight to normal operation and never forces the fans.

Two inputs come from outside the block. A comparator supplies the supply-good flag, with its threshold near 0.75 V. A bus decoder supplies a single-cycle pulse for each valid addressed transaction. The timeout stands for about 4.6 s of real time. Here it is the parameter `TIMEOUT_CYC`, so simulation can use a short count. Once the block reaches normal operation it stays there until the next reset.

Top module: `pofs_seq`

## Requirements
- R1: While `rst_ni` is low, and after its release, the block is in the waiting state (state code 0, WAIT_RAIL), and all four outputs are low.
- R2: While in the waiting state with `rail_good_i` low, no timeout elapses, however long the wait. `fan_full_o` stays low. A `bus_hit_i` pulse sets `normal_o` and `load_dflt_o` on the next clock edge.
- R3: In the waiting state, the edge that samples `rail_good_i` high enters the timing state. With no `bus_hit_i`, the block stays in timing for exactly `TIMEOUT_CYC` cycles. `fan_full_o` rises at the next edge after that.
- R4: A `bus_hit_i` sampled during any timing cycle, the last one included, goes to normal operation. `normal_o` and `load_dflt_o` rise, and `fan_full_o` and `fan_off_o` stay low.
- R5: `fan_full_o` stays high for as long as no `bus_hit_i` arrives. The edge that samples a `bus_hit_i` in full-speed clears `fan_full_o` and sets `fan_off_o`, `load_dflt_o` and `normal_o` together.
- R6: `load_dflt_o` is high for exactly one cycle, the first cycle of normal operation. `fan_off_o` is high for exactly one cycle, and only when normal operation is entered from full-speed.
- R7: Once `normal_o` is high, it stays high until reset. Further `rail_good_i` changes and `bus_hit_i` pulses cause no `fan_full_o`, `fan_off_o` or `load_dflt_o`.
- R8: `rail_good_i` falling during the timing state does not stop the timeout or reset it. Full-speed is still reached on schedule.
- R9: When `bus_hit_i` and `rail_good_i` are both high on the same edge in the waiting state, the bus transaction wins. The block enters normal operation directly, and no timeout runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rail_good_i | input | 1 | Processor supply above its good threshold |
| bus_hit_i | input | 1 | One-cycle pulse for each valid addressed bus transaction |
| fan_full_o | output | 1 | Command to drive the fans at full speed |
| fan_off_o | output | 1 | One-cycle command to switch the fans off |
| load_dflt_o | output | 1 | One-cycle strobe to load the default settings |
| normal_o | output | 1 | Normal operation has been entered |

## Verification
Timeout expiry and a bus transaction can fall in the same cycle. The bench provokes this by pulsing `bus_hit_i` so that it is sampled in the last timing cycle, the one in which the counter would expire. It judges the result at the next edge: normal operation with a load strobe, and no full-speed or fan-off command. A second collision puts `bus_hit_i` and `rail_good_i` on the same waiting-state edge. The bench expects direct entry to normal operation, with no timeout afterwards.

// File: rtl/pofs_pkg.sv
package pofs_pkg;
  typedef enum logic [1:0] {
    WAIT_RAIL  = 2'd0,
    TIMING     = 2'd1,
    FULL_SPEED = 2'd2,
    NORMAL     = 2'd3
  } fs_state_e;
endpackage

// File: rtl/pofs_timer.sv
module pofs_timer #(
  parameter int unsigned TIMEOUT_CYC = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (start_i)                   cnt_q <= LOAD_VAL;
    else if (run_i && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = run_i && (cnt_q == '0);

  // R3
  start_run_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !run_i);

  // R3
  load_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> cnt_q == LOAD_VAL);
endmodule

// File: rtl/pofs_fsm.sv
module pofs_fsm
  import pofs_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      rail_good_i,
  input  logic      bus_hit_i,
  input  logic      expired_i,
  output fs_state_e state_o,
  output logic      start_o,
  output logic      run_o,
  output logic      enter_norm_o,
  output logic      leave_full_o
);
  fs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WAIT_RAIL: begin
        // bus access outranks rail-good
        if (bus_hit_i)        state_d = NORMAL;
        else if (rail_good_i) state_d = TIMING;
      end
      TIMING: begin
        // bus access outranks expiry in the same cycle
        if (bus_hit_i)        state_d = NORMAL;
        else if (expired_i)   state_d = FULL_SPEED;
      end
      FULL_SPEED: if (bus_hit_i) state_d = NORMAL;
      default:    state_d = NORMAL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= WAIT_RAIL;
    else         state_q <= state_d;
  end

  assign state_o      = state_q;
  assign start_o      = (state_q == WAIT_RAIL) && (state_d == TIMING);
  assign run_o        = (state_q == TIMING);
  assign enter_norm_o = (state_q != NORMAL) && (state_d == NORMAL);
  assign leave_full_o = (state_q == FULL_SPEED) && (state_d == NORMAL);

  // R3
  expiry_to_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TIMING && expired_i && !bus_hit_i) |=> state_q == FULL_SPEED);

  // R9
  hit_wins_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WAIT_RAIL && bus_hit_i) |=> state_q == NORMAL);

  // R2
  wait_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WAIT_RAIL && !bus_hit_i && !rail_good_i) |=> state_q == WAIT_RAIL);
endmodule

// File: rtl/pofs_out.sv
module pofs_out
  import pofs_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  fs_state_e state_i,
  input  logic      enter_norm_i,
  input  logic      leave_full_i,
  output logic      fan_full_o,
  output logic      fan_off_o,
  output logic      load_dflt_o,
  output logic      normal_o
);
  logic load_q, off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= 1'b0;
      off_q  <= 1'b0;
    end else begin
      load_q <= enter_norm_i;
      off_q  <= leave_full_i;
    end
  end

  assign fan_full_o  = (state_i == FULL_SPEED);
  assign normal_o    = (state_i == NORMAL);
  assign load_dflt_o = load_q;
  assign fan_off_o   = off_q;

  // R6
  load_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_dflt_o |=> !load_dflt_o);

  // R6
  load_on_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_dflt_o |-> normal_o && !$past(normal_o));

  // R5
  off_after_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fan_off_o |-> load_dflt_o && $past(fan_full_o));

  // R7
  normal_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    normal_o |=> normal_o);

  // R5
  full_norm_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fan_full_o && normal_o));
endmodule

// File: rtl/pofs_seq.sv
module pofs_seq
  import pofs_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rail_good_i,
  input  logic bus_hit_i,
  output logic fan_full_o,
  output logic fan_off_o,
  output logic load_dflt_o,
  output logic normal_o
);
  fs_state_e state;
  logic      start, run, expired, enter_norm, leave_full;

  pofs_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .run_i     (run),
    .expired_o (expired)
  );

  pofs_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rail_good_i  (rail_good_i),
    .bus_hit_i    (bus_hit_i),
    .expired_i    (expired),
    .state_o      (state),
    .start_o      (start),
    .run_o        (run),
    .enter_norm_o (enter_norm),
    .leave_full_o (leave_full)
  );

  pofs_out u_out (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .state_i      (state),
    .enter_norm_i (enter_norm),
    .leave_full_i (leave_full),
    .fan_full_o   (fan_full_o),
    .fan_off_o    (fan_off_o),
    .load_dflt_o  (load_dflt_o),
    .normal_o     (normal_o)
  );

  initial begin
    // R3
    timeout_param_chk: assert (TIMEOUT_CYC >= 1);
  end
endmodule

// File: tb/tb_pofs_seq.sv
`timescale 1ns/1ps
module tb_pofs_seq;
  localparam int unsigned T = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rail_good_i = 1'b0;
  logic bus_hit_i = 1'b0;
  logic fan_full_o, fan_off_o, load_dflt_o, normal_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pofs_seq #(.TIMEOUT_CYC(T)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .rail_good_i(rail_good_i), .bus_hit_i(bus_hit_i),
    .fan_full_o(fan_full_o), .fan_off_o(fan_off_o),
    .load_dflt_o(load_dflt_o), .normal_o(normal_o)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_all(string req, logic ff, logic fo, logic ld, logic nm);
    chk(req, "fan_full_o", fan_full_o, ff);
    chk(req, "fan_off_o", fan_off_o, fo);
    chk(req, "load_dflt_o", load_dflt_o, ld);
    chk(req, "normal_o", normal_o, nm);
  endtask

  task automatic do_reset();
    rail_good_i = 1'b0;
    bus_hit_i = 1'b0;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk_all("R1", 0, 0, 0, 0);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk_all("R1", 0, 0, 0, 0);
  endtask

  // R2
  task automatic t_idle_hit();
    do_reset();
    for (int i = 0; i < 3*T; i++) begin
      @(negedge clk);
      chk("R2", "fan_full_o idle", fan_full_o, 1'b0);
    end
    bus_hit_i = 1'b1;
    @(negedge clk);
    bus_hit_i = 1'b0;
    chk_all("R2", 0, 0, 1, 1);
    @(negedge clk);
    chk_all("R6", 0, 0, 0, 1);
  endtask

  // R3 R5 R6
  task automatic t_timeout();
    do_reset();
    rail_good_i = 1'b1;
    for (int j = 1; j <= T; j++) begin
      @(negedge clk);
      chk("R3", "fan_full_o timing", fan_full_o, 1'b0);
    end
    @(negedge clk);
    chk_all("R3", 1, 0, 0, 0);
    repeat (5) @(negedge clk);
    chk_all("R5", 1, 0, 0, 0);
    bus_hit_i = 1'b1;
    @(negedge clk);
    bus_hit_i = 1'b0;
    chk_all("R5", 0, 1, 1, 1);
    @(negedge clk);
    chk_all("R6", 0, 0, 0, 1);
  endtask

  // R4
  task automatic t_hit_mid();
    do_reset();
    rail_good_i = 1'b1;
    repeat (T/2) @(negedge clk);
    bus_hit_i = 1'b1;
    @(negedge clk);
    bus_hit_i = 1'b0;
    chk_all("R4", 0, 0, 1, 1);
    repeat (2*T) @(negedge clk);
    chk_all("R4", 0, 0, 0, 1);
  endtask

  // R4: hit in the expiry cycle
  task automatic t_hit_last();
    do_reset();
    rail_good_i = 1'b1;
    repeat (T) @(negedge clk);
    chk("R4", "fan_full_o before last", fan_full_o, 1'b0);
    bus_hit_i = 1'b1;
    @(negedge clk);
    bus_hit_i = 1'b0;
    chk_all("R4", 0, 0, 1, 1);
    @(negedge clk);
    chk_all("R6", 0, 0, 0, 1);
  endtask

  // R8
  task automatic t_rail_drop();
    do_reset();
    rail_good_i = 1'b1;
    @(negedge clk);
    rail_good_i = 1'b0;
    for (int j = 2; j <= T; j++) begin
      @(negedge clk);
      chk("R8", "fan_full_o early", fan_full_o, 1'b0);
    end
    @(negedge clk);
    chk_all("R8", 1, 0, 0, 0);
  endtask

  // R7
  task automatic t_sticky();
    do_reset();
    bus_hit_i = 1'b1;
    @(negedge clk);
    bus_hit_i = 1'b0;
    chk_all("R7", 0, 0, 1, 1);
    for (int i = 0; i < 2*T + 4; i++) begin
      rail_good_i = i[0];
      bus_hit_i = (i % 3 == 0);
      @(negedge clk);
      chk_all("R7", 0, 0, 0, 1);
    end
    bus_hit_i = 1'b0;
    rail_good_i = 1'b0;
  endtask

  // R9
  task automatic t_same_edge();
    do_reset();
    rail_good_i = 1'b1;
    bus_hit_i = 1'b1;
    @(negedge clk);
    bus_hit_i = 1'b0;
    chk_all("R9", 0, 0, 1, 1);
    repeat (T + 3) @(negedge clk);
    chk_all("R9", 0, 0, 0, 1);
  endtask

  always @(posedge clk) cycles++;

  initial begin
    wait (cycles > 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle_hit();
    t_timeout();
    t_hit_mid();
    t_hit_last();
    t_rail_drop();
    t_sticky();
    t_same_edge();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule